// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block sits on the address/command path of a memory module. It registers an incoming command word on each rising clock edge and drives the captured word on two identical output buses. The captured word holds the data bits and the two active-low chip-select inputs.

Two chip-select inputs gate the register. While gating is on and both chip selects are deasserted (high), no command is addressed to the module. The outputs then hold their last value, which saves switching on the module's many loads. Driving the gate-enable input low turns this gating off, so every clock loads a new word and the chip selects pass through as ordinary bits.

Each accepted word comes with a parity bit. The block checks even parity over the data bits and that bit. On a mismatch it drives an active-low error flag, which stays asserted for a fixed number of cycles. Reset clears every register, drives both output buses to zero and holds the error flag at its inactive level.

Top module: `cmd_regbuf`

## Requirements
- R1: While `rst` is high at a rising edge, both output words become all zeros and `perr_n_o` becomes 1. After `rst` is released, the outputs stay zero until the first accepted word is registered.
- R2: The two output words `q_a_o` and `q_b_o` are equal after every clock edge.
- R3: Word layout: bits [DATA_W-1:0] carry `d_i`, bit DATA_W carries `cs0_n_i` and bit DATA_W+1 carries `cs1_n_i`. A word sampled at a rising edge is visible on the outputs right after that edge.
- R4: With `gate_en_i`=1 and both `cs0_n_i` and `cs1_n_i` equal to 1 at an edge, both output words keep their previous value.
- R5: With `gate_en_i`=1 and at least one of `cs0_n_i`/`cs1_n_i` equal to 0 at an edge, the word is accepted and the outputs update.
- R6: With `gate_en_i`=0 every edge accepts a word, including words with both chip-select bits at 1.
- R7: Even parity: an accepted word with XOR(`d_i`, `par_i`) = 1 drives `perr_n_o` low after the next rising edge, one cycle after the word appears on the outputs.
- R8: Once low, `perr_n_o` stays low for HOLD_CYC (default 2) cycles and then returns to 1, unless a new mismatch restarts the window.
- R9: A word that is held off by chip-select gating is not checked, so its parity never affects `perr_n_o`.
- R10: Reset takes priority over gating and over a running error window. It forces zeros on the outputs and `perr_n_o` to 1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| d_i | input | DATA_W | Command/address data bits |
| cs0_n_i | input | 1 | Chip select 0, active low |
| cs1_n_i | input | 1 | Chip select 1, active low |
| gate_en_i | input | 1 | 1 = chip-select gating on, 0 = off |
| par_i | input | 1 | Parity bit sent with the data |
| q_a_o | output | DATA_W+2 | Registered word, copy A |
| q_b_o | output | DATA_W+2 | Registered word, copy B |
| perr_n_o | output | 1 | Parity error flag, active low |

## Verification
The bench builds the buffer with DATA_W=8 and HOLD_CYC=2. With that size it can sweep every data value, both parity values and all eight combinations of gate enable and chip selects in one run. Every gating case therefore meets both good and bad parity. Back-to-back mismatches exercise the window restart, and resets land in the middle of error windows. Expected words and the error-window timing come from a small arithmetic model in the bench.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;
  // number of chip-select bits carried in the output word
  localparam int unsigned NUM_CS   = 2;
  // number of identical output copies
  localparam int unsigned NUM_COPY = 2;

  // width needed to count 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cmd_regbuf_accept.sv
module cmd_regbuf_accept
  import cmd_regbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 26,
  localparam int unsigned WORD_W = DATA_W + NUM_CS
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic              cs0_n_i,
  input  logic              cs1_n_i,
  input  logic              gate_en_i,
  input  logic              par_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o,
  output logic              par_bad_o
);
  // word is blocked only when gating is on and no chip select is active
  always_comb begin
    load_o    = !(gate_en_i && cs0_n_i && cs1_n_i);
    word_o    = {cs1_n_i, cs0_n_i, d_i};
    par_bad_o = ^{par_i, d_i};
  end
endmodule

// File: rtl/cmd_regbuf_outbank.sv
module cmd_regbuf_outbank #(
  parameter int unsigned WORD_W = 28,
  parameter int unsigned NCOPY  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_i,
  input  logic [WORD_W-1:0]             word_i,
  output logic [NCOPY-1:0][WORD_W-1:0]  q_o
);
  // one register per output copy, each with its own flops
  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst)         q_o[c] <= '0;
      else if (load_i) q_o[c] <= word_i;
    end

    if (c > 0) begin : g_cmp
      // R2
      copy_match_chk: assert property (@(posedge clk) disable iff (rst)
        q_o[c] == q_o[0]);
    end
  end

  // R4
  gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(q_o[0]));

  // R5
  load_update_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> q_o[0] == $past(word_i));
endmodule

// File: rtl/cmd_regbuf_parchk.sv
module cmd_regbuf_parchk
  import cmd_regbuf_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 2,
  localparam int unsigned CNT_W   = cnt_width(HOLD_CYC)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic par_bad_i,
  output logic perr_n_o
);
  logic             bad_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (bad_q)              cnt_nxt = CNT_W'(HOLD_CYC);
    else if (cnt_q != '0)   cnt_nxt = cnt_q - CNT_W'(1);
    else                    cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_q    <= 1'b0;
      cnt_q    <= '0;
      perr_n_o <= 1'b1;
    end else begin
      bad_q    <= load_i && par_bad_i;
      cnt_q    <= cnt_nxt;
      perr_n_o <= (cnt_nxt == '0);
    end
  end

  // R7
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(perr_n_o) |-> $past(bad_q));

  // R9
  gated_nocheck_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> !bad_q);

  if (HOLD_CYC >= 2) begin : g_width
    // R8
    low_width_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(perr_n_o) |=> !perr_n_o);
  end
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmd_regbuf_pkg::*;
#(
  parameter int unsigned DATA_W   = 26,
  parameter int unsigned HOLD_CYC = 2,
  localparam int unsigned WORD_W  = DATA_W + NUM_CS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d_i,
  input  logic              cs0_n_i,
  input  logic              cs1_n_i,
  input  logic              gate_en_i,
  input  logic              par_i,
  output logic [WORD_W-1:0] q_a_o,
  output logic [WORD_W-1:0] q_b_o,
  output logic              perr_n_o
);
  logic                               load;
  logic                               par_bad;
  logic [WORD_W-1:0]                  word;
  logic [NUM_COPY-1:0][WORD_W-1:0]    q_bank;

  cmd_regbuf_accept #(.DATA_W(DATA_W)) accept_i (
    .d_i       (d_i),
    .cs0_n_i   (cs0_n_i),
    .cs1_n_i   (cs1_n_i),
    .gate_en_i (gate_en_i),
    .par_i     (par_i),
    .load_o    (load),
    .word_o    (word),
    .par_bad_o (par_bad)
  );

  cmd_regbuf_outbank #(.WORD_W(WORD_W), .NCOPY(NUM_COPY)) bank_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .word_i (word),
    .q_o    (q_bank)
  );

  cmd_regbuf_parchk #(.HOLD_CYC(HOLD_CYC)) parchk_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .par_bad_i (par_bad),
    .perr_n_o  (perr_n_o)
  );

  assign q_a_o = q_bank[0];
  assign q_b_o = q_bank[1];
endmodule

// File: tb/cmd_regbuf_tb_top.sv
module cmd_regbuf_tb_top;
  localparam int DW = 8;
  localparam int WW = DW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] d = '0;
  logic          cs0 = 1'b1, cs1 = 1'b1, ge = 1'b1, par = 1'b0;
  logic [WW-1:0] qa, qb;
  logic          perr_n;

  int total = 0;
  int bad   = 0;

  logic [WW-1:0] exp_w = '0;
  logic          p1 = 1'b0, p2 = 1'b0;

  always #2.5 clk = ~clk;

  cmd_regbuf #(.DATA_W(DW), .HOLD_CYC(2)) dut_i (
    .clk(clk), .rst(rst), .d_i(d), .cs0_n_i(cs0), .cs1_n_i(cs1),
    .gate_en_i(ge), .par_i(par), .q_a_o(qa), .q_b_o(qb), .perr_n_o(perr_n)
  );

  task automatic chk_w(input string req, input logic [WW-1:0] act, input logic [WW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s word act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic chk_b(input string req, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s perr_n act=%b exp=%b", req, act, expv);
    end
  endtask

  // drive one cycle, update model, check after the edge
  task automatic step(input logic r, input logic [DW-1:0] dv, input logic c0,
                      input logic c1, input logic g, input logic pv);
    logic acc, bad_now, exp_low;
    string wreq, preq;
    @(negedge clk);
    rst = r; d = dv; cs0 = c0; cs1 = c1; ge = g; par = pv;
    acc     = !(g && c0 && c1);
    bad_now = acc && ((^dv) ^ pv);
    @(posedge clk);
    #1;
    if (r) begin
      exp_w = '0; p1 = 1'b0; p2 = 1'b0; exp_low = 1'b0;
      wreq = "R1_R10"; preq = "R1_R10";
    end else begin
      exp_low = p1 | p2;
      p2 = p1; p1 = bad_now;
      if (acc) exp_w = {c1, c0, dv};
      if (!acc) wreq = "R4";
      else if (!g) wreq = "R6_R3";
      else wreq = "R5_R3";
      preq = (g && c0 && c1) ? "R9_R8" : "R7_R8";
    end
    chk_w(wreq, qa, exp_w);
    chk_w("R2", qb, qa);
    chk_b(preq, perr_n, !exp_low);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R1 reset state
    step(1, '0, 1, 1, 1, 0);
    step(1, 8'hFF, 0, 0, 0, 0);
    // R1 after release, gated word keeps outputs zero
    step(0, 8'h5A, 1, 1, 1, 1);
    chk_w("R1", qa, '0);
    // R3 layout: only chip select 0 active
    step(0, 8'h81, 0, 1, 1, 0);
    chk_w("R3", qa, {1'b1, 1'b0, 8'h81});
    // back-to-back errors restart window (R8)
    step(0, 8'h01, 0, 0, 1, 0);
    step(0, 8'h03, 0, 0, 1, 1);
    step(0, 8'h07, 0, 0, 1, 0);
    step(0, 8'h00, 0, 0, 1, 0);
    step(0, 8'h00, 0, 0, 1, 0);
    step(0, 8'h00, 0, 0, 1, 0);
    step(0, 8'h00, 0, 0, 1, 0);
    // exhaustive sweep
    for (int v = 0; v < 256; v++) begin
      for (int p = 0; p < 2; p++) begin
        for (int c = 0; c < 8; c++) begin
          step(0, 8'(v), c[0], c[1], c[2], p[0]);
          // R10: reset inside a running error window
          if ((v % 37) == 5 && p == 1 && c == 3)
            step(1, 8'(v), 1, 1, 1, 0);
        end
      end
    end
    step(0, 8'h00, 1, 1, 1, 0);
    step(0, 8'h00, 1, 1, 1, 0);
    step(0, 8'h00, 1, 1, 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule